// File: doc/BRIEF.md
# Fixed-Cycle Program Sequencer with Conditional Skip

This block drives the instruction stream of a sample-rate signal processor. An address counter walks the program store from the first word to the last, one word per clock, and then starts again at the first word. With the clock at 1024 times the sample rate, a pass over the 1024-word store lasts exactly one sample period. No jump, call or loop exists. The only control instruction is a conditional skip. When the skip's condition holds, the words that follow it are still fetched and still take their slots, but each goes to the datapath as a no-operation. Every pass therefore lasts the same number of clocks, whatever the flags do.

The skip word has four fields: a fixed opcode, an inversion bit, a flag selector and a count. A taken skip marks the next N slots as dead. A dead range that reaches past the last address carries on into the start of the next pass. A skip word that falls inside a dead range is dead as well, so it cannot restart or extend the count. A one-clock frame marker goes high whenever the address is zero, which gives the datapath its sample boundary.

Top module: `fixed_pass_sequencer`

## Requirements
- R1: After reset the program address is 0. Each clock it rises by one, and after 1023 it returns to 0. It never stalls or jumps.
- R2: `frame_start` is high in exactly those cycles where `prog_addr` is 0.
- R3: In a live slot, `issue_live` is 1 and `issue_instr` equals `prog_data`.
- R4: A word is a skip when bits [15:12] are 4'hF. Bit 11 inverts the condition, bits [10:8] select one of eight flags, and bits [7:0] give the count N. The condition is `cond_flags[sel]` XOR the inversion bit, sampled in the same cycle the skip word is addressed.
- R5: A live skip whose condition is true and whose N lies between 1 and 255 makes the N slots that follow dead. In a dead slot `issue_live` is 0 and `issue_instr` is the all-zero no-operation word. Live issue resumes in the slot after those N.
- R6: A skip whose condition is false, or whose count is 0, kills no slot.
- R7: A skip word inside a dead range is itself dead. It does not reload the remaining count, so the range ends where the earlier skip placed it.
- R8: A dead range that runs past address 1023 continues at address 0 of the next pass until its count is used up.
- R9: During reset and in the first cycle after it, `prog_addr` is 0, `frame_start` is 1 and `issue_live` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, 1024 times the sample rate |
| rst_n | input | 1 | Synchronous reset, active low |
| prog_addr | output | 10 | Address of the program word for the current slot |
| prog_data | input | 16 | Program word read at `prog_addr` in the same cycle |
| cond_flags | input | 8 | Condition flags tested by a skip word |
| issue_instr | output | 16 | Word issued to the datapath, all zero in a dead slot |
| issue_live | output | 1 | 1 for a live slot, 0 for a slot turned into a no-operation |
| frame_start | output | 1 | High for the one slot per pass at address 0 |

## Verification
Two things can fall in the same cycle: a dead slot and a skip word, and a dead range and the wrap of the address back to 0. The program puts a second skip, with its condition forced true, inside the range of an earlier skip. It also puts a skip three words before the end of the store, so that its range spans the frame marker. A behavioural model tracks the remaining count as a plain integer and compares every output in every slot. The slot just after the nested range must be live, and the slots at addresses 0 to 6 of each following pass must be dead while `frame_start` is still high at address 0.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int ADDR_W  = 10;
  localparam int CNT_W   = 8;
  localparam int FLAG_W  = 8;
  localparam int SEL_W   = $clog2(FLAG_W);
  localparam int OP_W    = 4;
  localparam int INSTR_W = OP_W + 1 + SEL_W + CNT_W;
  localparam logic [OP_W-1:0]    SKIP_OP  = '1;
  localparam logic [INSTR_W-1:0] NOP_WORD = '0;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic             inv;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] cnt;
  } skip_word_t;

  function automatic logic is_skip(input logic [INSTR_W-1:0] w);
    skip_word_t f;
    f = skip_word_t'(w);
    return f.op == SKIP_OP;
  endfunction

  function automatic logic skip_cond(input logic [INSTR_W-1:0] w,
                                     input logic [FLAG_W-1:0] flags);
    skip_word_t f;
    f = skip_word_t'(w);
    return flags[f.sel] ^ f.inv;
  endfunction

  function automatic logic [CNT_W-1:0] skip_len(input logic [INSTR_W-1:0] w);
    skip_word_t f;
    f = skip_word_t'(w);
    return f.cnt;
  endfunction
endpackage

// File: rtl/fps_addr_ctr.sv
module fps_addr_ctr #(
  parameter int ADDR_W = fps_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] pc,
  output logic              at_zero
);
  logic run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc    <= '0;
      run_q <= 1'b0;
    end else begin
      pc    <= pc + 1'b1;
      run_q <= 1'b1;
    end
  end

  assign at_zero = (pc == '0);

  // R1
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> pc == ADDR_W'($past(pc) + 1'b1));
endmodule

// File: rtl/fps_skip_ctl.sv
module fps_skip_ctl
  import fps_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] word,
  input  logic [FLAG_W-1:0]  flags,
  output logic               dead,
  output logic               fire
);
  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] len;

  assign len  = skip_len(word);
  assign dead = (left_q != '0);
  assign fire = !dead && is_skip(word) && skip_cond(word, flags) && (len != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     left_q <= '0;
    else if (fire)  left_q <= len;
    else if (dead)  left_q <= left_q - 1'b1;
  end

  // R5
  load_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> dead && left_q == $past(len));
  // R7
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dead |=> left_q == CNT_W'($past(left_q) - 1'b1));
  // R6
  stay_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dead && !fire) |=> !dead);
endmodule

// File: rtl/fixed_pass_sequencer.sv
module fixed_pass_sequencer
  import fps_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [AW-1:0]      prog_addr,
  input  logic [INSTR_W-1:0] prog_data,
  input  logic [FLAG_W-1:0]  cond_flags,
  output logic [INSTR_W-1:0] issue_instr,
  output logic               issue_live,
  output logic               frame_start
);
  logic slot_dead;
  logic skip_fire;

  fps_addr_ctr #(.ADDR_W(AW)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .pc     (prog_addr),
    .at_zero(frame_start)
  );

  fps_skip_ctl u_skip (
    .clk  (clk),
    .rst_n(rst_n),
    .word (prog_data),
    .flags(cond_flags),
    .dead (slot_dead),
    .fire (skip_fire)
  );

  assign issue_live  = !slot_dead;
  assign issue_instr = slot_dead ? NOP_WORD : prog_data;

  // R2
  marker_then_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> prog_addr == AW'(1));
  // R5
  dead_is_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_live |-> issue_instr == NOP_WORD);
  // R7
  fire_only_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_fire |-> issue_live);
endmodule

// File: tb/tb_fixed_pass_sequencer.sv
module tb_fixed_pass_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  prog_addr;
  logic [15:0] prog_data;
  logic [7:0]  cond_flags = 8'h00;
  logic [15:0] issue_instr;
  logic        issue_live;
  logic        frame_start;

  logic [15:0] mem [1024];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign prog_data = mem[prog_addr];

  fixed_pass_sequencer dut (
    .clk(clk), .rst_n(rst_n), .prog_addr(prog_addr), .prog_data(prog_data),
    .cond_flags(cond_flags), .issue_instr(issue_instr),
    .issue_live(issue_live), .frame_start(frame_start)
  );

  function automatic logic [15:0] mk_skip(int inv, int sel, int n);
    return {4'hF, inv[0], sel[2:0], n[7:0]};
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int pc_m;
    int left_m;
    int prev_pc;
    int pass_m;
    for (int a = 0; a < 1024; a++) mem[a] = {4'(a % 15), 12'(a * 7)};
    mem[10]   = mk_skip(0, 0, 5);
    mem[30]   = mk_skip(1, 2, 3);
    mem[50]   = mk_skip(0, 1, 0);
    mem[70]   = mk_skip(0, 3, 6);
    mem[72]   = mk_skip(0, 5, 200);
    mem[100]  = mk_skip(0, 1, 255);
    mem[1020] = mk_skip(0, 7, 10);

    repeat (3) @(negedge clk);
    #1;
    // R9 reset state while reset is held
    chk(prog_addr == 0, "R9", "addr in reset", prog_addr, 0);
    chk(frame_start == 1, "R9", "frame in reset", frame_start, 1);
    chk(issue_live == 1, "R9", "live in reset", issue_live, 1);
    @(negedge clk);
    rst_n = 1'b1;

    pc_m = 0; left_m = 0; prev_pc = -1; pass_m = 0;
    for (int cyc = 0; cyc < 3 * 1024 + 20; cyc++) begin
      int word;
      int sel;
      int inv;
      int cnt;
      int fl;
      bit exp_live;
      string tag;
      if (pc_m == 50 || pc_m == 70 || pc_m == 72 || pc_m == 1020) fl = 255;
      else fl = ((cyc * 29) ^ (cyc >> 3)) & 255;
      cond_flags = 8'(fl);
      #1;
      word = mem[pc_m];
      exp_live = (left_m == 0);
      if (cyc == 0) tag = "R9";
      else if (prev_pc == 30) tag = "R4";
      else if (prev_pc == 50) tag = "R6";
      else if (pc_m == 77) tag = "R7";
      else if (pass_m > 0 && pc_m <= 7) tag = "R8";
      else if (!exp_live) tag = "R5";
      else tag = "R3";
      // R1 address walk
      chk(prog_addr == pc_m, "R1", "prog_addr", prog_addr, pc_m);
      // R2 frame marker
      chk(frame_start == (pc_m == 0), "R2", "frame_start", frame_start, pc_m == 0);
      chk(issue_live == exp_live, tag, "issue_live", issue_live, exp_live);
      chk(issue_instr == (exp_live ? word : 0), tag, "issue_instr",
          issue_instr, exp_live ? word : 0);
      // model next state
      sel = (word >> 8) & 7;
      inv = (word >> 11) & 1;
      cnt = word & 255;
      if (exp_live && ((word >> 12) == 15) && ((((fl >> sel) & 1) != inv)) && cnt > 0)
        left_m = cnt;
      else if (left_m > 0)
        left_m = left_m - 1;
      prev_pc = pc_m;
      pc_m = (pc_m + 1) % 1024;
      if (pc_m == 0) pass_m++;
      @(negedge clk);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule